// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block turns single-word host requests into the strobe sequence of a small multiplexed-address DRAM. The modelled array holds sixteen 8-bit cells in four rows of four columns. A host request carries a 4-bit cell address, a write flag and write data. The controller splits the address into a row part and a column part and sends them one after the other over a single 2-bit address bus. It frames the row part with an active-low row strobe and the column part with an active-low column strobe.

Once a row is opened it stays open in a row buffer. A later request to the same row needs only a column strobe. A request to a different row first closes the open one, which writes the buffer back to the array, and then opens the new row. The precharge time and the row-to-column delay are parameters counted in clock cycles.

A free-running refresh timer raises a request every `REF_PERIOD` cycles. That request wins over the host. The controller closes any open row and then strobes each of the four rows in ascending order with the row strobe alone. Only after that does it accept host traffic again. Reads return their byte in a single-cycle response pulse.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset `dram_ras_n` and `dram_cas_n` are high, `rsp_valid` is low, `req_ready` is high and no row is open, so the first access always issues a row strobe.
- R2: When the addressed row is not open, exactly one falling edge of `dram_ras_n` occurs for the access, with the row number `req_addr[3:2]` on `dram_addr` during that low period before the column strobe.
- R3: Every accepted access produces exactly one `dram_cas_n` low pulse of one cycle, only while `dram_ras_n` is low, with the column number `req_addr[1:0]` on `dram_addr`.
- R4: An access whose row equals the open row issues no new row strobe: `dram_ras_n` stays low from the previous access through the column strobe.
- R5: After a row strobe falls, `dram_ras_n` is low for exactly `T_RCD` cycles before the first column strobe of that row. Between two low periods of `dram_ras_n` it is high for at least `T_RP` cycles.
- R6: A write updates the row buffer, and the buffer is stored back into the array when its row closes. A read returns the byte most recently written to that address, or zero if none was written since reset.
- R7: `rsp_valid` is high for exactly one cycle, in the cycle right after the column strobe of a read, carrying the read byte on `rsp_rdata`. Writes produce no response.
- R8: Each refresh interval of `REF_PERIOD` cycles, counted from reset, yields one refresh pass. A pass is four row-strobe-only pulses on rows 0, 1, 2, 3 in that order, each low for exactly `T_RCD` cycles, with no column strobe.
- R9: A pending refresh has priority over the host. `req_ready` is low from the refresh request until the pass ends, and a host request held valid meanwhile is served only afterwards.
- R10: After a refresh pass no row is open, so the next host access issues a row strobe even if it addresses the row that was open before the refresh.
- R11: `req_ready` is high only while the controller is idle; it is never high during a column strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Cell address: bits 3:2 row, bits 1:0 column |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_addr | output | 2 | Shared row/column address bus |

## Verification
The two functions that can fall in the same cycle are an expiring refresh interval and a host request that is already valid. The bench provokes the clash by streaming accesses back to back, raising `req_valid` again in the cycle after each column strobe. Some timer expiries therefore land while a request waits at an idle controller. Each such overlap is judged by three checks: the request must wait with `req_ready` low, the four strobe-only pulses must appear in row order first, and the served access must then reopen its row and return data consistent with the behavioural memory model.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    localparam int ROW_AW = 2;
    localparam int COL_AW = 2;
    localparam int ADDR_W = ROW_AW + COL_AW;
    localparam int DATA_W = 8;
    localparam int N_ROWS = 1 << ROW_AW;
    localparam int N_COLS = 1 << COL_AW;
    localparam int BUS_W  = (ROW_AW > COL_AW) ? ROW_AW : COL_AW;

    typedef logic [ROW_AW-1:0] row_t;
    typedef logic [COL_AW-1:0] col_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_ACT,
        PH_CAS
    } phase_e;

    typedef struct packed {
        logic  wr;
        row_t  row;
        col_t  col;
        byte_t wdata;
    } hreq_t;

    typedef struct packed {
        logic  load;
        row_t  load_row;
        logic  store;
        row_t  store_row;
        logic  wr_en;
        col_t  col;
        byte_t wdata;
    } arr_cmd_t;

    function automatic row_t addr_row(input addr_t a);
        return a[ADDR_W-1:COL_AW];
    endfunction

    function automatic col_t addr_col(input addr_t a);
        return a[COL_AW-1:0];
    endfunction
endpackage

// File: rtl/pgd_refresh_timer.sv
module pgd_refresh_timer #(
    parameter int REF_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(REF_PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(REF_PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (cnt == LAST) begin
                cnt  <= '0;
                pend <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                if (ack) pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgd_cell_array.sv
module pgd_cell_array
    import pgd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arr_cmd_t cmd,
    input  col_t     rd_col,
    output byte_t    rd_data
);
    byte_t mem  [N_ROWS][N_COLS];
    byte_t rbuf [N_COLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N_ROWS; r++)
                for (int c = 0; c < N_COLS; c++)
                    mem[r][c] <= '0;
            for (int c = 0; c < N_COLS; c++)
                rbuf[c] <= '0;
        end else begin
            if (cmd.store)
                for (int c = 0; c < N_COLS; c++)
                    mem[cmd.store_row][c] <= rbuf[c];
            if (cmd.load) begin
                for (int c = 0; c < N_COLS; c++)
                    rbuf[c] <= mem[cmd.load_row][c];
            end else if (cmd.wr_en) begin
                rbuf[cmd.col] <= cmd.wdata;
            end
        end
    end

    assign rd_data = rbuf[rd_col];
endmodule

// File: rtl/pgd_sequencer.sv
module pgd_sequencer
    import pgd_pkg::*;
#(
    parameter int T_RCD = 2,
    parameter int T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  hreq_t            req,
    output logic             req_ready,
    input  logic             ref_pend,
    output logic             ref_ack,
    output arr_cmd_t         arr_cmd,
    output col_t             rd_col,
    input  byte_t            rd_byte,
    output logic             rsp_valid,
    output byte_t            rsp_data,
    output logic             ras_n,
    output logic             cas_n,
    output logic [BUS_W-1:0] bus_addr
);
    localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [ROW_AW:0] REF_END = (ROW_AW+1)'(N_ROWS);

    phase_e          phase, phase_n;
    logic [TW-1:0]   tmr, tmr_n;
    logic            open_flag;
    row_t            open_row;
    hreq_t           cur, cur_n;
    logic            in_ref, in_ref_n;
    logic [ROW_AW:0] ref_idx, ref_idx_n;
    logic            start_pre, start_act;
    row_t            act_row;

    assign req_ready = (phase == PH_IDLE) && !ref_pend;

    always_comb begin
        phase_n   = phase;
        tmr_n     = tmr;
        cur_n     = cur;
        in_ref_n  = in_ref;
        ref_idx_n = ref_idx;
        start_pre = 1'b0;
        start_act = 1'b0;
        act_row   = cur.row;
        ref_ack   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (ref_pend) begin
                    ref_ack   = 1'b1;
                    in_ref_n  = 1'b1;
                    ref_idx_n = '0;
                    if (open_flag) begin
                        start_pre = 1'b1;
                    end else begin
                        start_act = 1'b1;
                        act_row   = '0;
                    end
                end else if (req_valid) begin
                    cur_n = req;
                    if (open_flag && open_row == req.row) begin
                        phase_n = PH_CAS;
                    end else if (open_flag) begin
                        start_pre = 1'b1;
                    end else begin
                        start_act = 1'b1;
                        act_row   = req.row;
                    end
                end
            end
            PH_PRE: begin
                if (tmr == '0) begin
                    if (in_ref && ref_idx == REF_END) begin
                        phase_n  = PH_IDLE;
                        in_ref_n = 1'b0;
                    end else if (in_ref) begin
                        start_act = 1'b1;
                        act_row   = ref_idx[ROW_AW-1:0];
                    end else begin
                        start_act = 1'b1;
                        act_row   = cur.row;
                    end
                end else begin
                    tmr_n = tmr - 1'b1;
                end
            end
            PH_ACT: begin
                if (tmr == '0) begin
                    if (in_ref) begin
                        start_pre = 1'b1;
                        ref_idx_n = ref_idx + 1'b1;
                    end else begin
                        phase_n = PH_CAS;
                    end
                end else begin
                    tmr_n = tmr - 1'b1;
                end
            end
            PH_CAS: phase_n = PH_IDLE;
            default: phase_n = PH_IDLE;
        endcase
        if (start_pre) begin
            phase_n = PH_PRE;
            tmr_n   = TW'(T_RP - 1);
        end
        if (start_act) begin
            phase_n = PH_ACT;
            tmr_n   = TW'(T_RCD - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            tmr       <= '0;
            cur       <= '0;
            in_ref    <= 1'b0;
            ref_idx   <= '0;
            open_flag <= 1'b0;
            open_row  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            phase   <= phase_n;
            tmr     <= tmr_n;
            cur     <= cur_n;
            in_ref  <= in_ref_n;
            ref_idx <= ref_idx_n;
            if (start_pre) open_flag <= 1'b0;
            if (start_act) begin
                open_flag <= 1'b1;
                open_row  <= act_row;
            end
            rsp_valid <= (phase == PH_CAS) && !cur.wr;
            if ((phase == PH_CAS) && !cur.wr) rsp_data <= rd_byte;
        end
    end

    always_comb begin
        arr_cmd.load      = start_act;
        arr_cmd.load_row  = act_row;
        arr_cmd.store     = start_pre;
        arr_cmd.store_row = open_row;
        arr_cmd.wr_en     = (phase == PH_CAS) && cur.wr;
        arr_cmd.col       = cur.col;
        arr_cmd.wdata     = cur.wdata;
    end

    assign rd_col = cur.col;
    assign ras_n  = !open_flag;
    assign cas_n  = (phase != PH_CAS);

    always_comb begin
        case (phase)
            PH_ACT:  bus_addr = BUS_W'(open_row);
            PH_CAS:  bus_addr = BUS_W'(cur.col);
            default: bus_addr = '0;
        endcase
    end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgd_pkg::*;
#(
    parameter int T_RCD      = 2,
    parameter int T_RP       = 2,
    parameter int REF_PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic [BUS_W-1:0]  dram_addr
);
    hreq_t    host_req;
    arr_cmd_t arr_cmd;
    col_t     rd_col;
    byte_t    rd_byte;
    logic     ref_pend;
    logic     ref_ack;

    always_comb begin
        host_req.wr    = req_write;
        host_req.row   = addr_row(req_addr);
        host_req.col   = addr_col(req_addr);
        host_req.wdata = req_wdata;
    end

    pgd_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    pgd_sequencer #(.T_RCD(T_RCD), .T_RP(T_RP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (host_req),
        .req_ready (req_ready),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .arr_cmd   (arr_cmd),
        .rd_col    (rd_col),
        .rd_byte   (rd_byte),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .bus_addr  (dram_addr)
    );

    pgd_cell_array u_array (
        .clk     (clk),
        .rst     (rst),
        .cmd     (arr_cmd),
        .rd_col  (rd_col),
        .rd_data (rd_byte)
    );
endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic rsp_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic ref_pend
);
    a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    a_r3_cas_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |=> dram_cas_n);

    a_r7_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r7_rsp_follows_cas: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!dram_cas_n));

    a_r9_refresh_blocks_host: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

    a_r11_ready_idle_only: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> dram_cas_n);
endmodule

bind pgdram_ctrl pgdram_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .ref_pend   (ref_pend)
);

// File: tb/sim_pgdram_ctrl.sv
`timescale 1ns/1ps
module sim_pgdram_ctrl;
    localparam int T_RCD = 2;
    localparam int T_RP  = 3;
    localparam int REF_P = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       dram_ras_n, dram_cas_n;
    logic [1:0] dram_addr;

    always #2 clk = ~clk;

    pgdram_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .REF_PERIOD(REF_P)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_addr(dram_addr)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference state
    logic [7:0] model_mem [16];
    int         model_open = -1;
    int         cur_row = 0, cur_col = 0;
    bit         cur_rd = 0;
    logic [7:0] exp_rd_q [$];

    // monitor state
    bit mon_on = 0, prev_ras = 1, prev_cas = 1, first_fall = 1;
    bit run_cas = 0, run_ready = 0;
    int run_addr = 0, run_len = 0, high_len = 0;
    int ras_falls = 0, cas_cnt = 0, ref_pulses = 0, ref_next = 0, cyc = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (!prev_cas && cur_rd) begin
                check(rsp_valid === 1'b1, "R7 response in cycle after read CAS", rsp_valid, 1);
                if (rsp_valid && exp_rd_q.size() > 0) begin
                    automatic logic [7:0] e = exp_rd_q.pop_front();
                    check(rsp_rdata == e, "R6 R7 read data", rsp_rdata, e);
                end
            end else if (rsp_valid) begin
                check(0, "R7 unexpected response", 1, 0);
            end
            if (prev_ras && !dram_ras_n) begin
                ras_falls++;
                if (!first_fall) check(high_len >= T_RP, "R5 precharge length", high_len, T_RP);
                first_fall = 0;
                run_addr = dram_addr; run_len = 0; run_cas = 0; run_ready = 0;
            end
            if (!dram_ras_n) begin
                if (!run_cas && dram_cas_n) run_len++;
                if (req_ready) run_ready = 1;
            end
            if (!dram_cas_n) begin
                cas_cnt++;
                check(prev_cas == 1'b1, "R3 CAS one cycle", prev_cas, 1);
                check(dram_ras_n == 1'b0, "R3 CAS inside RAS", dram_ras_n, 0);
                check(dram_addr == cur_col, "R3 column on bus", dram_addr, cur_col);
                check(req_ready == 1'b0, "R11 ready low during CAS", req_ready, 0);
                if (!run_cas) begin
                    check(run_len == T_RCD, "R5 RAS to CAS delay", run_len, T_RCD);
                    check(run_addr == cur_row, "R2 row on bus at RAS", run_addr, cur_row);
                end
                run_cas = 1;
            end
            if (!prev_ras && dram_ras_n) begin
                if (!run_cas) begin
                    check(run_addr == ref_next, "R8 refresh row order", run_addr, ref_next);
                    check(run_len == T_RCD, "R8 refresh pulse width", run_len, T_RCD);
                    check(!run_ready, "R9 ready low in refresh", run_ready, 0);
                    ref_next = (ref_next + 1) % 4;
                    ref_pulses++;
                    model_open = -1;
                end
                high_len = 0;
            end
            if (dram_ras_n) high_len++;
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    int waits_total = 0;

    task automatic access(input bit wr, input int addr, input logic [7:0] wd, output int dras);
        int ras0, cas0, exp_ras, n, w;
        cur_row = addr >> 2; cur_col = addr & 3; cur_rd = !wr;
        req_write = wr; req_addr = 4'(addr); req_wdata = wd; req_valid = 1'b1;
        w = 0;
        while (!req_ready && w < 1000) begin step(); w++; end
        if (w > 0) waits_total++;
        ras0 = ras_falls; cas0 = cas_cnt;
        exp_ras = (model_open == cur_row) ? 0 : 1;
        if (wr) model_mem[addr] = wd; else exp_rd_q.push_back(model_mem[addr]);
        model_open = cur_row;
        step();
        req_valid = 1'b0;
        n = 0;
        while (cas_cnt == cas0 && n < 100) begin step(); n++; end
        check(cas_cnt - cas0 == 1, "R3 one CAS per access", cas_cnt - cas0, 1);
        dras = ras_falls - ras0;
        if (exp_ras == 0) check(dras == 0, "R4 page hit keeps row", dras, 0);
        else              check(dras == 1, "R2 row miss opens row", dras, 1);
        step();
    endtask

    task automatic wait_refresh();
        int r0 = ref_pulses;
        int n = 0;
        while (ref_pulses < r0 + 4 && n < 3000) begin step(); n++; end
        check(ref_pulses >= r0 + 4, "R8 refresh pass seen", ref_pulses - r0, 4);
        repeat (T_RP + 2) step();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int d;
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < 16; i++) model_mem[i] = 8'h00;
        repeat (5) step();
        check(dram_ras_n == 1'b1, "R1 RAS high in reset", dram_ras_n, 1);
        check(dram_cas_n == 1'b1, "R1 CAS high in reset", dram_cas_n, 1);
        rst = 1'b0;
        mon_on = 1;
        step();
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        check(dram_ras_n == 1'b1, "R1 no row open after reset", dram_ras_n, 1);

        // first access must open a row; then page hits in row 0
        access(1, 1, 8'hA5, d);
        check(d == 1, "R1 first access needs RAS", d, 1);
        access(1, 0, 8'h11, d);
        access(1, 2, 8'h22, d);
        access(1, 3, 8'h33, d);
        access(0, 1, 8'h00, d);
        check(d == 0, "R4 read hit without RAS", d, 0);

        // leave row 0 then come back: write-back must have happened
        access(1, 9, 8'h99, d);
        access(0, 1, 8'h00, d);
        access(0, 3, 8'h00, d);
        access(0, 9, 8'h00, d);

        // column-major fill: every access changes row
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                access(1, r * 4 + c, 8'((r * 4 + c) * 17 + 3), d);
        for (int a = 0; a < 16; a++) access(0, a, 8'h00, d);

        // refresh closes the open row
        access(1, 5, 8'h5C, d);
        wait_refresh();
        access(0, 6, 8'h00, d);
        check(d == 1, "R10 row closed after refresh", d, 1);
        access(0, 5, 8'h00, d);

        // back-to-back stream crossing several refresh intervals
        for (int k = 0; k < 300; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            access(seed[20], int'(seed[27:24]), seed[15:8], d);
        end
        check(waits_total > 0, "R9 refresh held off a waiting request", waits_total, 1);

        // idle through a refresh, then confirm the contents survived
        wait_refresh();
        for (int a = 0; a < 16; a++) access(0, a, 8'h00, d);
        repeat (T_RP + T_RCD + 4) step();
        check(ref_pulses % 4 == 0, "R8 refresh passes complete", ref_pulses % 4, 0);
        check((ref_pulses / 4 >= cyc / REF_P - 1) && (ref_pulses / 4 <= cyc / REF_P),
              "R8 refresh pass count", ref_pulses / 4, cyc / REF_P);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule